// File: doc/BRIEF.md
# Side-Restricted Channel Connection Block

This block sits between two neighbouring logic cells of a programmable fabric and joins the pins that each cell exposes on the facing side to a routing channel. The channel has four single-length wires and eight double-length wires. Each cell presents ten input pins and four output pins to the block. The ten inputs on a side consist of a register clock-enable, two wide-mux address bits and the LUT inputs that reach that side. Every input pin can pick up any channel wire. Every output pin can drive any single wire, but only the lower four double wires. A set of direct links lets an output of one cell feed an input of the other cell without using the channel.

All connection points are enable bits held in a serial configuration chain. The chain loads most significant bit first while `cfg_shift_en` is high, and its last stage comes out on `cfg_out` so that blocks can be chained. While the chain is loading, the configuration is not applied, and every pin and channel drive output of the block stays at 0. Wires are modelled behaviourally. A channel wire carries the OR of its external value (`chan_single_in` / `chan_double_in`) and every cell output that is enabled onto it. A wire with no enabled driver reads 0. The configuration and control pins are plain level signals. There is no valid/ready stream at the block's edge, because data passes through as combinational routing and there is nothing to back-pressure.

Top module: `cb_side_link`

## Requirements
- R1: When `rst_n` is low, the configuration chain is cleared. After reset, every pin output and channel drive reads 0, whatever the channel and cell outputs are.
- R2: The chain holds 384 bits. Each shift cycle moves every bit one place up and takes `cfg_in` into bit 0. `cfg_out` is bit 383, so the first bit shifted in during a 384-cycle load ends up at bit 383 (most significant bit first). While a new load is in progress, `cfg_out` emits the previous contents from bit 383 downwards.
- R3: While `cfg_shift_en` is high, `near_in`, `far_in`, `single_drive` and `double_drive` are all 0.
- R4: While `cfg_shift_en` is low, the configuration and `cfg_out` do not change, whatever happens on `cfg_in`.
- R5: Input pin p uses a 16-bit field at chain bits [16p+15:16p]. Pins 0–9 are the near cell's `near_in[0..9]` and pins 10–19 are `far_in[0..9]`. Field bits 0–3 connect single wire 0–3 to the pin.
- R6: Field bits 4–11 of an input pin field connect double wire 0–7 to the pin.
- R7: Output driver o uses an 8-bit field at chain bits [320+8o+7:320+8o]. Drivers 0–3 are `near_out[0..3]` and drivers 4–7 are `far_out[0..3]`. Field bits 0–3 enable the output onto single wire 0–3. This appears on `single_drive`, and input pins selecting that wire see the value.
- R8: Field bits 4–7 of an output driver field enable the output onto double wire 0–3. This appears on `double_drive`. Double wires 4–7 can only be driven from outside the block.
- R9: Field bits 12–15 of an input pin field connect output 0–3 of the opposite cell directly to the pin.
- R10: A pin or wire with several enabled sources carries their OR. A pin with no enabled source reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low reset; clears the configuration |
| cfg_shift_en | input | 1 | Shift the configuration chain by one bit per cycle |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Last chain stage, for chaining to the next block |
| chan_single_in | input | 4 | External value on each single wire |
| chan_double_in | input | 8 | External value on each double wire |
| single_drive | output | 4 | Cell outputs driven onto the single wires |
| double_drive | output | 4 | Cell outputs driven onto double wires 0–3 |
| near_out | input | 4 | Side outputs of the cell in the same tile |
| far_out | input | 4 | Side outputs of the neighbouring cell |
| near_in | output | 10 | Side inputs of the cell in the same tile |
| far_in | output | 10 | Side inputs of the neighbouring cell |

## Verification
The hardest case to reach is a path that passes through the block twice. A cell output is driven onto a wire, and an input pin then reads that wire back. Or one cell's output feeds the other cell through a direct link. Each such path needs two enable fields, hundreds of chain positions apart, to be set in the same load. The stimulus builds the whole configuration as a vector computed from the field layout in the requirements and shifts it in with one long load. It then drives single cell outputs one at a time, so each expected pin value traces back to one field pair. A second load over the first checks the serial order on `cfg_out` bit by bit, and also checks that the outputs stay silent while that load is running.

// File: rtl/cb_side_pkg.sv
package cb_side_pkg;
  parameter int SINGLE_W = 4;
  parameter int DOUBLE_W = 8;
  parameter int PINS_IN  = 10;
  parameter int PINS_OUT = 4;

  localparam int DRIVEN_DOUBLES = DOUBLE_W / 2;
  localparam int SEL_W     = SINGLE_W + DOUBLE_W + PINS_OUT;
  localparam int DRV_W     = SINGLE_W + DRIVEN_DOUBLES;
  localparam int IN_TOTAL  = 2 * PINS_IN;
  localparam int OUT_TOTAL = 2 * PINS_OUT;
  localparam int SEL_BITS  = IN_TOTAL * SEL_W;
  localparam int DRV_BITS  = OUT_TOTAL * DRV_W;
  localparam int CFG_BITS  = SEL_BITS + DRV_BITS;

  // Position of bit k inside the field of input pin p
  function automatic int sel_bit(input int p, input int k);
    return p * SEL_W + k;
  endfunction

  // Position of bit k inside the field of output driver o
  function automatic int drv_bit(input int o, input int k);
    return SEL_BITS + o * DRV_W + k;
  endfunction
endpackage

// File: rtl/cb_cfg_chain.sv
module cb_cfg_chain #(
  parameter int N = 384
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [N-1:0] bits_q,
  output logic         bit_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits_q <= '0;
    else if (shift_en) bits_q <= {bits_q[N-2:0], bit_in};
  end

  assign bit_out = bits_q[N-1];
endmodule

// File: rtl/cb_wire_resolve.sv
module cb_wire_resolve
  import cb_side_pkg::*;
(
  input  logic                    active,
  input  logic [OUT_TOTAL-1:0]    cell_out,
  input  logic [DRV_BITS-1:0]     drv_cfg,
  input  logic [SINGLE_W-1:0]     chan_single_in,
  input  logic [DOUBLE_W-1:0]     chan_double_in,
  output logic [SINGLE_W-1:0]     single_drive,
  output logic [DRIVEN_DOUBLES-1:0] double_drive,
  output logic [SINGLE_W-1:0]     single_seen,
  output logic [DOUBLE_W-1:0]     double_seen
);
  logic [SINGLE_W-1:0]       single_acc;
  logic [DRIVEN_DOUBLES-1:0] double_acc;

  always_comb begin
    single_acc = '0;
    double_acc = '0;
    for (int o = 0; o < OUT_TOTAL; o++) begin
      for (int w = 0; w < SINGLE_W; w++)
        single_acc[w] = single_acc[w] | (cell_out[o] & drv_cfg[o*DRV_W + w]);
      for (int d = 0; d < DRIVEN_DOUBLES; d++)
        double_acc[d] = double_acc[d] | (cell_out[o] & drv_cfg[o*DRV_W + SINGLE_W + d]);
    end
  end

  assign single_drive = active ? single_acc : '0;
  assign double_drive = active ? double_acc : '0;
  assign single_seen  = chan_single_in | single_drive;

  genvar g;
  generate
    for (g = 0; g < DOUBLE_W; g++) begin : g_double
      if (g < DRIVEN_DOUBLES) begin : g_driven
        assign double_seen[g] = chan_double_in[g] | double_drive[g];
      end else begin : g_external
        assign double_seen[g] = chan_double_in[g];
      end
    end
  endgenerate
endmodule

// File: rtl/cb_pin_select.sv
module cb_pin_select
  import cb_side_pkg::*;
(
  input  logic                active,
  input  logic [SEL_W-1:0]    sel,
  input  logic [SINGLE_W-1:0] single_seen,
  input  logic [DOUBLE_W-1:0] double_seen,
  input  logic [PINS_OUT-1:0] opposite_out,
  output logic                pin
);
  logic [SEL_W-1:0] sources;

  assign sources = {opposite_out, double_seen, single_seen};
  assign pin     = active & (|(sel & sources));
endmodule

// File: rtl/cb_side_link.sv
module cb_side_link
  import cb_side_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_shift_en,
  input  logic                      cfg_in,
  output logic                      cfg_out,
  input  logic [SINGLE_W-1:0]       chan_single_in,
  input  logic [DOUBLE_W-1:0]       chan_double_in,
  output logic [SINGLE_W-1:0]       single_drive,
  output logic [DRIVEN_DOUBLES-1:0] double_drive,
  input  logic [PINS_OUT-1:0]       near_out,
  input  logic [PINS_OUT-1:0]       far_out,
  output logic [PINS_IN-1:0]        near_in,
  output logic [PINS_IN-1:0]        far_in
);
  logic [CFG_BITS-1:0] cfg_q;
  logic [SINGLE_W-1:0] single_seen;
  logic [DOUBLE_W-1:0] double_seen;
  logic [IN_TOTAL-1:0] pins_all;
  logic                active;

  assign active = ~cfg_shift_en;

  cb_cfg_chain #(.N(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift_en),
    .bit_in   (cfg_in),
    .bits_q   (cfg_q),
    .bit_out  (cfg_out)
  );

  cb_wire_resolve u_wires (
    .active         (active),
    .cell_out       ({far_out, near_out}),
    .drv_cfg        (cfg_q[CFG_BITS-1:SEL_BITS]),
    .chan_single_in (chan_single_in),
    .chan_double_in (chan_double_in),
    .single_drive   (single_drive),
    .double_drive   (double_drive),
    .single_seen    (single_seen),
    .double_seen    (double_seen)
  );

  genvar p;
  generate
    for (p = 0; p < IN_TOTAL; p++) begin : g_pin
      cb_pin_select u_sel (
        .active       (active),
        .sel          (cfg_q[p*SEL_W +: SEL_W]),
        .single_seen  (single_seen),
        .double_seen  (double_seen),
        .opposite_out ((p < PINS_IN) ? far_out : near_out),
        .pin          (pins_all[p])
      );
    end
  endgenerate

  assign near_in = pins_all[PINS_IN-1:0];
  assign far_in  = pins_all[IN_TOTAL-1:PINS_IN];
endmodule

// File: rtl/cb_side_link_chk.sv
module cb_side_link_chk
  import cb_side_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_shift_en,
  input logic                      cfg_out,
  input logic [SINGLE_W-1:0]       chan_single_in,
  input logic [DOUBLE_W-1:0]       chan_double_in,
  input logic [SINGLE_W-1:0]       single_drive,
  input logic [DRIVEN_DOUBLES-1:0] double_drive,
  input logic [PINS_OUT-1:0]       near_out,
  input logic [PINS_OUT-1:0]       far_out,
  input logic [PINS_IN-1:0]        near_in,
  input logic [PINS_IN-1:0]        far_in
);
  // R3
  silent_while_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |-> (near_in == '0 && far_in == '0 && single_drive == '0 && double_drive == '0));

  // R4
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift_en |=> $stable(cfg_out));

  // R10
  no_source_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_single_in == '0 && chan_double_in == '0 && near_out == '0 && far_out == '0)
      |-> (near_in == '0 && far_in == '0));

  // R7
  drive_needs_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_drive != '0 || double_drive != '0) |-> ((near_out | far_out) != '0));
endmodule

bind cb_side_link cb_side_link_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_shift_en   (cfg_shift_en),
  .cfg_out        (cfg_out),
  .chan_single_in (chan_single_in),
  .chan_double_in (chan_double_in),
  .single_drive   (single_drive),
  .double_drive   (double_drive),
  .near_out       (near_out),
  .far_out        (far_out),
  .near_in        (near_in),
  .far_in         (far_in)
);

// File: tb/cb_side_link_tb.sv
module cb_side_link_tb;
  import cb_side_pkg::*;

  localparam int EXP_W = 2 * PINS_IN + SINGLE_W + DRIVEN_DOUBLES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shift_en = 1'b0;
  logic cfg_in = 1'b0;
  logic cfg_out;
  logic [SINGLE_W-1:0] chan_single_in = '0;
  logic [DOUBLE_W-1:0] chan_double_in = '0;
  logic [SINGLE_W-1:0] single_drive;
  logic [DRIVEN_DOUBLES-1:0] double_drive;
  logic [PINS_OUT-1:0] near_out = '0;
  logic [PINS_OUT-1:0] far_out = '0;
  logic [PINS_IN-1:0] near_in;
  logic [PINS_IN-1:0] far_in;

  int total = 0;
  int bad = 0;
  logic [EXP_W-1:0] exp_q[$];
  string tag_q[$];
  logic [CFG_BITS-1:0] cfg_a;

  always #2 clk = ~clk;

  cb_side_link u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .chan_single_in(chan_single_in), .chan_double_in(chan_double_in),
    .single_drive(single_drive), .double_drive(double_drive),
    .near_out(near_out), .far_out(far_out), .near_in(near_in), .far_in(far_in)
  );

  // Driver: apply one pattern at a falling edge and queue its expected result
  task automatic apply(input logic [SINGLE_W-1:0] cs, input logic [DOUBLE_W-1:0] cd,
                       input logic [PINS_OUT-1:0] no, input logic [PINS_OUT-1:0] fo,
                       input logic [PINS_IN-1:0] e_near, input logic [PINS_IN-1:0] e_far,
                       input logic [SINGLE_W-1:0] e_sd, input logic [DRIVEN_DOUBLES-1:0] e_dd,
                       input string tag);
    @(negedge clk);
    chan_single_in = cs; chan_double_in = cd; near_out = no; far_out = fo;
    exp_q.push_back({e_near, e_far, e_sd, e_dd});
    tag_q.push_back(tag);
  endtask

  // Shift a whole vector in, MSB first; optionally check what falls out
  task automatic load(input logic [CFG_BITS-1:0] vec, input logic check_chain,
                      input logic [CFG_BITS-1:0] prev);
    int miss = 0;
    for (int k = CFG_BITS - 1; k >= 0; k--) begin
      @(negedge clk);
      if (check_chain && cfg_out !== prev[k]) begin
        if (miss == 0)
          $display("FAIL R2 chain bit %0d actual=%b expected=%b", k, cfg_out, prev[k]);
        miss++;
      end
      cfg_shift_en = 1'b1;
      cfg_in = vec[k];
      // R3: outputs silent during the load even with every source active
      exp_q.push_back('0);
      tag_q.push_back("R3");
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    if (check_chain) begin
      total++;
      if (miss != 0) bad++;
    end
  endtask

  // Monitor: compare one queued item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() != 0) begin
        logic [EXP_W-1:0] e;
        logic [EXP_W-1:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {near_in, far_in, single_drive, double_drive};
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_a = '0;
    cfg_a[sel_bit(0, 2)]        = 1'b1; // near pin0 <- single2
    cfg_a[sel_bit(3, 4 + 6)]    = 1'b1; // near pin3 <- double6
    cfg_a[sel_bit(2, 4 + 1)]    = 1'b1; // near pin2 <- double1
    cfg_a[sel_bit(5, 12 + 3)]   = 1'b1; // near pin5 <- far_out3
    cfg_a[sel_bit(7, 1)]        = 1'b1; // near pin7 <- single1
    cfg_a[sel_bit(7, 4 + 7)]    = 1'b1; // near pin7 <- double7
    cfg_a[sel_bit(14, 3)]       = 1'b1; // far pin4 <- single3
    cfg_a[sel_bit(19, 4)]       = 1'b1; // far pin9 <- double0
    cfg_a[sel_bit(10, 12)]      = 1'b1; // far pin0 <- near_out0
    cfg_a[drv_bit(1, 3)]        = 1'b1; // near_out1 -> single3
    cfg_a[drv_bit(6, 4 + 1)]    = 1'b1; // far_out2 -> double1
    cfg_a[drv_bit(7, 4 + 3)]    = 1'b1; // far_out3 -> double3 (chain bit 383)

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: cleared configuration, everything active on the inputs
    apply('1, '1, '1, '1, '0, '0, '0, '0, "R1");

    load(cfg_a, 1'b0, '0);
    apply('0, '0, '0, '0, '0, '0, '0, '0, "R10 idle");
    apply(4'b0100, '0, '0, '0, 10'h001, '0, '0, '0, "R5");
    apply('0, 8'h40, '0, '0, 10'h008, '0, '0, '0, "R6");
    apply('0, '0, 4'b0010, '0, '0, 10'h010, 4'b1000, '0, "R7");
    apply('0, '0, '0, 4'b0100, 10'h004, '0, '0, 4'b0010, "R8");
    apply('0, '0, '0, 4'b1000, 10'h020, '0, '0, 4'b1000, "R9 far to near");
    apply('0, '0, 4'b0001, '0, '0, 10'h001, '0, '0, "R9 near to far");
    apply(4'b0010, '0, '0, '0, 10'h080, '0, '0, '0, "R10 single leg");
    apply('0, 8'h80, '0, '0, 10'h080, '0, '0, '0, "R10 double leg");
    apply('0, 8'h01, '0, '0, '0, 10'h200, '0, '0, "R6 far pin");
    apply('0, 8'h02, '0, 4'b0100, 10'h004, '0, '0, 4'b0010, "R10 two drivers");

    // R4: toggle cfg_in with shift disabled; chain output and function hold
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_in = i[0];
    end
    @(negedge clk);
    total++;
    if (cfg_out !== 1'b1) begin
      bad++;
      $display("FAIL R4 cfg_out actual=%b expected=1", cfg_out);
    end
    apply('0, '0, '0, 4'b1000, 10'h020, '0, '0, 4'b1000, "R4");

    // R2 + R3: load all zeros over cfg_a with every source active
    @(negedge clk);
    chan_single_in = '1; chan_double_in = '1; near_out = '1; far_out = '1;
    load('0, 1'b1, cfg_a);
    apply('1, '1, '1, '1, '0, '0, '0, '0, "R10 no enables");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    load(cfg_a, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset wipes a loaded configuration
    apply('1, '1, '1, '1, '0, '0, '0, '0, "R1 after load");

    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule